// File: doc/BRIEF.md
# Load-Use Interlock Stall Counter

This block tracks the one-instruction load-use hazard of a single-issue pipeline. Each instruction arrives on a valid/ready stream. It carries three things: an optional load destination register, a source count, and up to two source register numbers. The block keeps one lock token, which holds the register loaded by the instruction accepted just before. When the instruction now on the stream reads that register, the block raises a combinational stall flag.

On every accepted instruction three saturating counters update:
- the stall count grows by the stall flag;
- the cycle count grows by one;
- the instruction count grows by one.

The lock token then takes the new instruction's load destination. If that instruction loads nothing, the token takes the empty code 30, which no general register (0 to 15) can equal.

Back-pressure rules: an instruction is accepted on a rising clock edge where both `ins_valid` and `ins_ready` are high. `ins_ready` is low while reset is applied. It rises on the first clock edge after reset is released and then stays high, so the block never holds the stream off. While `ins_valid` is low, no state changes, and the lock token survives any number of idle cycles.

Top module: `lsi_tracker`

## Requirements
- R1: During reset all three counters read 0 and `ins_ready` is low. The first instruction after reset never stalls. `ins_ready` is high from the first clock edge after reset release and stays high.
- R2: An accepted instruction with `ins_ld_en`=1 makes `ins_ld_reg` the lock token. The next instruction stalls if it reads that register.
- R3: An accepted instruction with `ins_ld_en`=0 sets the token to the empty code 30. The next instruction then never stalls, even if one of its sources is 30.
- R4: Source count encoding on `ins_nsrc`: 0 means no sources, 1 means `ins_src_a` only, 2 or 3 means both `ins_src_a` and `ins_src_b`. With count 1, `ins_src_b` has no effect on `stall`.
- R5: With two sources, `stall` is high when either source equals the token. It is a single stall when both sources match.
- R6: With source count 0, `stall` stays low whatever the source fields hold.
- R7: `stall` is combinational and is high only while `ins_valid` is high. Cycles without acceptance leave the token and all counters unchanged.
- R8: On the accepting edge the stall count grows by one exactly when `stall` is high.
- R9: The cycle count and the instruction count each grow by one on every accepting edge.
- R10: All counters are CNT_W bits wide and hold at 2^CNT_W-1 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Instruction present on the stream |
| ins_ready | output | 1 | Block accepts instructions (high after reset) |
| ins_ld_en | input | 1 | Instruction loads a register |
| ins_ld_reg | input | REG_W (5) | Load destination register number |
| ins_nsrc | input | 2 | Source count: 0 none, 1 source A, 2/3 both |
| ins_src_a | input | REG_W (5) | First source register number |
| ins_src_b | input | REG_W (5) | Second source register number |
| stall | output | 1 | Current instruction hits the lock token |
| stall_count | output | CNT_W (32) | Saturating stall tally |
| cycle_count | output | CNT_W (32) | Saturating retired-instruction cycle tally |
| inst_count | output | CNT_W (32) | Saturating accepted-instruction tally |

## Verification
The assertions check the following on every cycle:
- how the token follows a load, an empty instruction and an idle cycle;
- that `ready` never drops once raised;
- that a stall only appears while a token is held;
- that each counter steps by exactly one or holds at its ceiling;
- that the cycle and instruction counts agree.

Which source lanes are compared for each source count, and the single stall when both sources match, come only from the bench. It sweeps every load register, every first source and several second-source patterns against a reference model. A narrow counter width lets the same sweep drive the counters into saturation.

// File: rtl/lsi_pkg.sv
package lsi_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_ONE  = 2'd1,
    SRC_TWO  = 2'd2,
    SRC_TWOX = 2'd3
  } src_cnt_e;

  localparam int unsigned NSRC = 2;

  function automatic logic lane_used(input logic [1:0] cnt, input int unsigned lane);
    return (32'(cnt) > lane);
  endfunction
endpackage

// File: rtl/lsi_lock_track.sv
module lsi_lock_track #(
  parameter int unsigned REG_W     = 5,
  parameter int unsigned LOCK_NONE = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             ld_en,
  input  logic [REG_W-1:0] ld_reg,
  output logic [REG_W-1:0] lock_q
);
  localparam logic [REG_W-1:0] NONE_CODE = REG_W'(LOCK_NONE);

  logic [REG_W-1:0] cur_lock;

  // token produced by the instruction now being accepted
  always_comb begin
    cur_lock = NONE_CODE;
    if (ld_en) cur_lock = ld_reg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lock_q <= NONE_CODE;
    else if (accept) lock_q <= cur_lock;
  end

  p_lock_from_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ld_en) |=> (lock_q == $past(ld_reg)));
  p_lock_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !ld_en) |=> (lock_q == NONE_CODE));
  p_lock_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(lock_q));
endmodule

// File: rtl/lsi_hazard_cmp.sv
module lsi_hazard_cmp
  import lsi_pkg::*;
#(
  parameter int unsigned REG_W     = 5,
  parameter int unsigned LOCK_NONE = 30
) (
  input  logic                       valid,
  input  logic [REG_W-1:0]           lock_q,
  input  logic [1:0]                 nsrc,
  input  logic [NSRC-1:0][REG_W-1:0] srcs,
  output logic                       hit
);
  localparam logic [REG_W-1:0] NONE_CODE = REG_W'(LOCK_NONE);

  logic [NSRC-1:0] lane_hit;
  logic            token_live;

  assign token_live = (lock_q != NONE_CODE);

  for (genvar g = 0; g < NSRC; g++) begin : g_lane
    assign lane_hit[g] = lane_used(nsrc, g) && (srcs[g] == lock_q);
  end

  // any lane match counts once
  assign hit = valid && token_live && (|lane_hit);
endmodule

// File: rtl/lsi_sat_counter.sv
module lsi_sat_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   count <= '0;
    else if (inc && count != TOP) count <= count + 1'b1;
  end

  p_sat_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (count == TOP) |=> (count == TOP));
  p_step_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && count != TOP) |=> (count == $past(count) + 1'b1));
  p_no_inc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(count));
endmodule

// File: rtl/lsi_tracker.sv
module lsi_tracker
  import lsi_pkg::*;
#(
  parameter int unsigned REG_W     = 5,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned LOCK_NONE = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  output logic             ins_ready,
  input  logic             ins_ld_en,
  input  logic [REG_W-1:0] ins_ld_reg,
  input  logic [1:0]       ins_nsrc,
  input  logic [REG_W-1:0] ins_src_a,
  input  logic [REG_W-1:0] ins_src_b,
  output logic             stall,
  output logic [CNT_W-1:0] stall_count,
  output logic [CNT_W-1:0] cycle_count,
  output logic [CNT_W-1:0] inst_count
);
  localparam logic [REG_W-1:0] NONE_CODE = REG_W'(LOCK_NONE);
  localparam logic [CNT_W-1:0] CNT_TOP   = {CNT_W{1'b1}};

  logic                       ready_q;
  logic                       accept;
  logic [REG_W-1:0]           lock_q;
  logic [NSRC-1:0][REG_W-1:0] srcs;
  logic                       hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign ins_ready = ready_q;
  assign accept    = ins_valid && ready_q;
  assign srcs[0]   = ins_src_a;
  assign srcs[1]   = ins_src_b;

  lsi_lock_track #(.REG_W(REG_W), .LOCK_NONE(LOCK_NONE)) u_lock (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .ld_en(ins_ld_en), .ld_reg(ins_ld_reg), .lock_q(lock_q)
  );

  lsi_hazard_cmp #(.REG_W(REG_W), .LOCK_NONE(LOCK_NONE)) u_cmp (
    .valid(ins_valid), .lock_q(lock_q), .nsrc(ins_nsrc),
    .srcs(srcs), .hit(hit)
  );

  assign stall = hit;

  lsi_sat_counter #(.W(CNT_W)) u_stall_cnt (
    .clk(clk), .rst_n(rst_n), .inc(accept && hit), .count(stall_count)
  );
  lsi_sat_counter #(.W(CNT_W)) u_cycle_cnt (
    .clk(clk), .rst_n(rst_n), .inc(accept), .count(cycle_count)
  );
  lsi_sat_counter #(.W(CNT_W)) u_inst_cnt (
    .clk(clk), .rst_n(rst_n), .inc(accept), .count(inst_count)
  );

  p_ready_stays_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ins_ready |=> ins_ready);
  p_stall_needs_token_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (lock_q != NONE_CODE));
  p_stall_needs_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> ins_valid);
  p_stall_counted_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && stall && stall_count != CNT_TOP) |=> (stall_count == $past(stall_count) + 1'b1));
  p_cycle_eq_inst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_count == inst_count);
  p_stall_le_inst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall_count <= inst_count);
endmodule

// File: tb/lsi_tracker_bench.sv
`timescale 1ns/100ps
module lsi_tracker_bench;
  localparam int CW  = 8;
  localparam int TOP = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ins_valid = 1'b0;
  logic ins_ready;
  logic ins_ld_en = 1'b0;
  logic [4:0] ins_ld_reg = '0;
  logic [1:0] ins_nsrc = '0;
  logic [4:0] ins_src_a = '0;
  logic [4:0] ins_src_b = '0;
  logic stall;
  logic [CW-1:0] stall_count, cycle_count, inst_count;

  int n_checks = 0;
  int n_fail = 0;
  int m_lock = -1;
  int m_stall = 0;
  int m_inst = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lsi_tracker #(.REG_W(5), .CNT_W(CW), .LOCK_NONE(30)) u_lsi_tracker (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_ld_en(ins_ld_en), .ins_ld_reg(ins_ld_reg), .ins_nsrc(ins_nsrc),
    .ins_src_a(ins_src_a), .ins_src_b(ins_src_b), .stall(stall),
    .stall_count(stall_count), .cycle_count(cycle_count), .inst_count(inst_count)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat_inc(input int v);
    return (v >= TOP) ? TOP : v + 1;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    ins_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R1 ready low in reset", ins_ready, 0);
    check("R1 stall count reset", stall_count, 0);
    check("R1 cycle count reset", cycle_count, 0);
    check("R1 inst count reset", inst_count, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 ready after release", ins_ready, 1);
    m_lock = -1; m_stall = 0; m_inst = 0;
  endtask

  // drive one instruction, check stall before edge and counters after it
  task automatic issue(input string req, input bit ld, input int ldr, input int ns,
                       input int a, input int b);
    bit exp_hit;
    @(negedge clk);
    ins_valid = 1'b1; ins_ld_en = ld; ins_ld_reg = 5'(ldr);
    ins_nsrc = 2'(ns); ins_src_a = 5'(a); ins_src_b = 5'(b);
    #1;
    exp_hit = (m_lock >= 0) && ((ns >= 1 && a == m_lock) || (ns >= 2 && b == m_lock));
    check({req, " stall"}, stall, exp_hit);
    @(posedge clk); #1;
    m_inst = sat_inc(m_inst);
    if (exp_hit) m_stall = sat_inc(m_stall);
    m_lock = ld ? ldr : -1;
    check("R8 stall count", stall_count, m_stall);
    check("R9 cycle count", cycle_count, m_inst);
    check("R9 inst count", inst_count, m_inst);
  endtask

  task automatic idle(input int n, input int a);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ins_valid = 1'b0; ins_nsrc = 2'd2; ins_src_a = 5'(a); ins_src_b = 5'(a);
      #1;
      check("R7 no stall when invalid", stall, 0);
      @(posedge clk); #1;
      check("R7 idle keeps inst count", inst_count, m_inst);
      check("R7 idle keeps stall count", stall_count, m_stall);
    end
  endtask

  initial begin
    do_reset();
    issue("R1 first after reset", 0, 0, 2, 30, 30);
    issue("R2 load r5", 1, 5, 0, 0, 0);
    issue("R2 use r5", 0, 0, 1, 5, 0);
    issue("R3 after non-load", 0, 0, 2, 30, 30);
    issue("R2 load r7", 1, 7, 0, 0, 0);
    issue("R4 src_b ignored", 0, 0, 1, 3, 7);
    issue("R2 load r9", 1, 9, 0, 0, 0);
    issue("R5 both match single stall", 0, 0, 2, 9, 9);
    check("R5 one stall tally", stall_count, 2);
    issue("R2 load r0", 1, 0, 0, 0, 0);
    issue("R6 zero sources", 0, 0, 0, 0, 0);
    issue("R2 load r12", 1, 12, 0, 0, 0);
    idle(3, 12);
    issue("R7 token survives idle", 0, 0, 3, 1, 12);
    issue("R2 load r4", 1, 4, 1, 2, 2);
    issue("R2 load-use chain", 1, 6, 1, 4, 0);
    issue("R2 chain second", 0, 0, 2, 0, 6);

    do_reset();
    for (int ld = 0; ld <= 16; ld++)
      for (int sa = 0; sa < 16; sa++)
        for (int ns = 0; ns < 4; ns++)
          for (int v = 0; v < 3; v++) begin
            int sb;
            sb = (v == 0) ? sa : (v == 1) ? ((ld == 16) ? 30 : ld) : ((ld + 5) % 16);
            issue("R2 sweep load", ld < 16, (ld < 16) ? ld : 0, 0, 0, 0);
            issue("R5 sweep use", 0, 0, ns, sa, sb);
          end
    check("R10 inst saturated", inst_count, TOP);
    check("R10 cycle saturated", cycle_count, TOP);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule